// File: doc/BRIEF.md
# Power Stage Fault Response Controller

This block decides how one phase of a digitally controlled buck converter reacts to protection events. Comparators and monitors outside it report level flags for faults (over-temperature, thermal shutdown, low-side and high-side overcurrent, output over- and undervoltage, start-up timeout, input under- and overvoltage). They also report warnings, a negative-overcurrent condition, a loss of synchronisation and a pin-strap decode failure. Register inputs set a response code for each fault (continue, restart or shutdown) and a mask bit for each maskable event. Another register input sets the restart delay as a multiplier times the soft-start rise time, counted in clock cycles.

From these inputs the block drives the enables of the high-side and low-side FETs, a pulse-by-pulse limit request, power-good, a sticky alert, a share-line pull-down and a restart-busy flag. When several faults are present, shutdown wins over restart and restart wins over continue. Overcurrent faults let the PWM run for a fixed number of PWM periods before switching stops. An output overvoltage holds the low-side FET on as a crowbar.

Top module: `psfr_ctrl`

## Requirements
- R1: After reset the stage is switching (`hs_en`=1, `ls_en`=1), `pgood`=1 with no event present, `alert`=0, `restart_busy`=0, `hs_limit`=0 and `share_pull_low`=0.
- R2: Fault bits in `flt_in` are 0 over-temperature, 1 thermal shutdown, 2 low-side OC, 3 high-side OC, 4 output OV, 5 output UV, 6 start-up timeout, 7 input UV and 8 input OV. Each fault's code sits in `flt_resp[2i+1:2i]`: 00 continue, 01 restart, 10 or 11 shutdown. When shutdown and restart faults occur together, the stage latches off and does not restart.
- R3: A low-side OC fault with a non-continue code keeps both FETs switching until the third `pwm_tick` seen in the overcurrent window. At the clock edge of that tick both FETs turn off. A non-OC fault in the window stops switching at once.
- R4: A high-side OC fault with a non-continue code asserts `hs_limit` for the whole three-tick window before both FETs turn off.
- R5: A restart holds both FETs off with `restart_busy`=1 for max(1, `restart_mult`×`rise_cycles`) clocks. Switching then resumes, unless a restart fault is still present, which starts a new wait. A shutdown-class fault during the wait latches the stage off.
- R6: An output OV fault (bit 4) with a non-continue code turns the high-side FET off and holds `ls_en`=1. With `ov_ls_latch`=0 the hold ends when `vout_low` is seen. With `ov_ls_latch`=1 it lasts until switching resumes.
- R7: With `neg_oc_en`=1, `neg_oc` turns only the low-side FET off and drops `pgood`. An active overvoltage crowbar still keeps `ls_en`=1.
- R8: Warning bits in `warn_in` are 0 over-temperature, 1 OC, 2 output OV and 3 output UV. A warning never changes the FET enables and sets `alert` one clock later. `pgood` stays 1 for all warnings except output UV.
- R9: `pgood` is 0 while any fault with a restart or shutdown code is present and while the stage is not in plain switching. A fault coded continue leaves `pgood`=1 and the FETs switching.
- R10: While `ramp_active`=1, output OV and UV faults and output OV and UV warnings are ignored entirely. All other events still act.
- R11: A `sync_fault` on a follower (`is_follower`=1) turns both FETs off, drives `share_pull_low`=1 and `pgood`=0. On a non-follower it has no effect. It never sets `alert`.
- R12: `strap_fail` turns both FETs off, drives `share_pull_low`=1 and `pgood`=0, and never sets `alert`.
- R13: `clear_faults` releases a latched-off stage and clears `alert` only in a cycle with no fault input asserted. The alert clear also needs no warning and no negative OC asserted.
- R14: A fault or warning whose bit is set in `flt_mask`/`warn_mask` keeps its FET response but does not set `alert`. Unmasked faults set `alert` one clock later whatever their code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pwm_tick | input | 1 | One pulse per PWM period |
| ramp_active | input | 1 | Soft-start ramp in progress |
| is_follower | input | 1 | Unit is a loop follower |
| flt_in | input | FAULT_N | Fault flags |
| flt_resp | input | 2*FAULT_N | Response code per fault |
| flt_mask | input | FAULT_N | Alert mask per fault |
| warn_in | input | WARN_N | Warning flags |
| warn_mask | input | WARN_N | Alert mask per warning |
| neg_oc | input | 1 | Negative overcurrent detected |
| neg_oc_en | input | 1 | Negative overcurrent response enabled |
| vout_low | input | 1 | Output below crowbar release threshold |
| ov_ls_latch | input | 1 | Keep crowbar latched until restart |
| sync_fault | input | 1 | Synchronisation lost |
| strap_fail | input | 1 | Pin-strap decode failed |
| clear_faults | input | 1 | Clear strobe |
| restart_mult | input | MULT_W | Restart delay multiplier |
| rise_cycles | input | RISE_W | Soft-start rise time in clocks |
| hs_en | output | 1 | High-side FET switching enable |
| ls_en | output | 1 | Low-side FET enable |
| hs_limit | output | 1 | Pulse-by-pulse current limit request |
| pgood | output | 1 | Power good |
| alert | output | 1 | Sticky alert |
| share_pull_low | output | 1 | Pull share line low |
| restart_busy | output | 1 | Restart delay running |

## Verification
The assertions assume that `restart_mult` and `rise_cycles` do not change while a restart wait runs. They also assume that `pwm_tick` is a single-cycle pulse and that every input changes only between clock edges. The stimulus drives every input at the falling edge and sets the delay registers before any fault is raised. It leaves them alone until the stage is back to switching, and it generates `pwm_tick` as a one-clock pulse every fourth cycle.

// File: rtl/psfr_pkg.sv
package psfr_pkg;
  localparam int FAULT_N = 9;
  localparam int WARN_N  = 4;

  localparam int F_OT    = 0;
  localparam int F_TSD   = 1;
  localparam int F_LSOC  = 2;
  localparam int F_HSOC  = 3;
  localparam int F_OVF   = 4;
  localparam int F_UVF   = 5;
  localparam int F_TON   = 6;
  localparam int F_VINUV = 7;
  localparam int F_VINOV = 8;

  localparam int W_OT = 0;
  localparam int W_OC = 1;
  localparam int W_OV = 2;
  localparam int W_UV = 3;

  // faults whose stop is delayed by PWM periods
  localparam logic [FAULT_N-1:0] OC_GROUP   = (FAULT_N'(1) << F_LSOC) | (FAULT_N'(1) << F_HSOC);
  // events ignored during the soft-start ramp
  localparam logic [FAULT_N-1:0] RAMP_FGATE = (FAULT_N'(1) << F_OVF) | (FAULT_N'(1) << F_UVF);
  localparam logic [WARN_N-1:0]  RAMP_WGATE = (WARN_N'(1) << W_OV) | (WARN_N'(1) << W_UV);

  typedef enum logic [1:0] {
    PH_RUN   = 2'd0,
    PH_OCWIN = 2'd1,
    PH_WAIT  = 2'd2,
    PH_OFF   = 2'd3
  } phase_t;
endpackage

// File: rtl/psfr_qual.sv
module psfr_qual
  import psfr_pkg::*;
(
  input  logic                 ramp_active,
  input  logic [FAULT_N-1:0]   flt_in,
  input  logic [2*FAULT_N-1:0] flt_resp,
  input  logic [WARN_N-1:0]    warn_in,
  output logic [FAULT_N-1:0]   flt_eff,
  output logic [WARN_N-1:0]    warn_eff,
  output logic [FAULT_N-1:0]   trip_sd,
  output logic [FAULT_N-1:0]   trip_rs
);
  for (genvar i = 0; i < FAULT_N; i++) begin : g_flt
    logic [1:0] code;
    assign code       = flt_resp[2*i +: 2];
    assign flt_eff[i] = flt_in[i] & ~(ramp_active & RAMP_FGATE[i]);
    assign trip_sd[i] = flt_eff[i] & code[1];
    assign trip_rs[i] = flt_eff[i] & (code == 2'b01);
  end

  for (genvar j = 0; j < WARN_N; j++) begin : g_wrn
    assign warn_eff[j] = warn_in[j] & ~(ramp_active & RAMP_WGATE[j]);
  end
endmodule

// File: rtl/psfr_rtimer.sv
module psfr_rtimer #(
  parameter int MULT_W = 8,
  parameter int RISE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic [MULT_W-1:0] mult,
  input  logic [RISE_W-1:0] rise,
  output logic              done
);
  localparam int CW = MULT_W + RISE_W;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] span;

  assign span = CW'(mult) * CW'(rise);
  assign done = (cnt_q <= CW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = span;
    else if (run && !done) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && run && !done) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R5
endmodule

// File: rtl/psfr_seq.sv
module psfr_seq
  import psfr_pkg::*;
#(
  parameter int OC_CYC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FAULT_N-1:0] trip_sd,
  input  logic [FAULT_N-1:0] trip_rs,
  input  logic               pwm_tick,
  input  logic               clear_ok,
  input  logic               tmr_done,
  input  logic               vout_low,
  input  logic               ov_ls_latch,
  output phase_t             phase,
  output logic               tmr_load,
  output logic               hs_pend,
  output logic               crow
);
  localparam int OCW = $clog2(OC_CYC + 1);

  phase_t         ph_q, ph_d;
  logic [OCW-1:0] occ_q, occ_d;
  logic           pend_q, pend_d;
  logic           hsp_q, hsp_d;
  logic           crow_q, crow_d;

  logic sd_imm, rs_imm, oc_sd, oc_rs, hs_trip, ovf_trip;

  assign sd_imm   = |(trip_sd & ~OC_GROUP);
  assign rs_imm   = |(trip_rs & ~OC_GROUP);
  assign oc_sd    = |(trip_sd & OC_GROUP);
  assign oc_rs    = |(trip_rs & OC_GROUP);
  assign hs_trip  = trip_sd[F_HSOC] | trip_rs[F_HSOC];
  assign ovf_trip = trip_sd[F_OVF] | trip_rs[F_OVF];

  always_comb begin
    ph_d     = ph_q;
    occ_d    = occ_q;
    pend_d   = pend_q;
    hsp_d    = hsp_q;
    tmr_load = 1'b0;
    unique case (ph_q)
      PH_RUN: begin
        if (sd_imm) ph_d = PH_OFF;
        else if (rs_imm) begin
          ph_d = PH_WAIT; tmr_load = 1'b1;
        end else if (oc_sd | oc_rs) begin
          ph_d = PH_OCWIN; occ_d = '0; pend_d = oc_sd; hsp_d = hs_trip;
        end
      end
      PH_OCWIN: begin
        if (sd_imm) ph_d = PH_OFF;
        else if (rs_imm) begin
          ph_d = PH_WAIT; tmr_load = 1'b1;
        end else begin
          pend_d = pend_q | oc_sd;
          hsp_d  = hsp_q | hs_trip;
          if (pwm_tick) begin
            if (occ_q == OCW'(OC_CYC - 1)) begin
              if (pend_d) ph_d = PH_OFF;
              else begin
                ph_d = PH_WAIT; tmr_load = 1'b1;
              end
            end else begin
              occ_d = occ_q + OCW'(1);
            end
          end
        end
      end
      PH_WAIT: begin
        if (sd_imm | oc_sd) ph_d = PH_OFF;
        else if (tmr_done) begin
          if (rs_imm | oc_rs) tmr_load = 1'b1;
          else                ph_d = PH_RUN;
        end
      end
      PH_OFF: begin
        if (clear_ok) ph_d = PH_RUN;
      end
      default: ph_d = PH_OFF;
    endcase
    if (ph_d != PH_OCWIN) begin
      pend_d = 1'b0;
      hsp_d  = 1'b0;
    end
    if (ovf_trip)                    crow_d = 1'b1;
    else if (ph_d == PH_RUN)         crow_d = 1'b0;
    else if (vout_low && !ov_ls_latch) crow_d = 1'b0;
    else                             crow_d = crow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_RUN;
      occ_q  <= '0;
      pend_q <= 1'b0;
      hsp_q  <= 1'b0;
      crow_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      occ_q  <= occ_d;
      pend_q <= pend_d;
      hsp_q  <= hsp_d;
      crow_q <= crow_d;
    end
  end

  assign phase   = ph_q;
  assign hs_pend = hsp_q;
  assign crow    = crow_q;

  AST_SHUTDOWN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_OFF && sd_imm) |=> (ph_q == PH_OFF)); // R2
  AST_OC_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_OCWIN && !pwm_tick && !sd_imm && !rs_imm) |=> (ph_q == PH_OCWIN)); // R3
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_OFF && !clear_ok) |=> (ph_q == PH_OFF)); // R13
endmodule

// File: rtl/psfr_ctrl.sv
module psfr_ctrl
  import psfr_pkg::*;
#(
  parameter int MULT_W = 8,
  parameter int RISE_W = 16,
  parameter int OC_CYC = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwm_tick,
  input  logic                 ramp_active,
  input  logic                 is_follower,
  input  logic [FAULT_N-1:0]   flt_in,
  input  logic [2*FAULT_N-1:0] flt_resp,
  input  logic [FAULT_N-1:0]   flt_mask,
  input  logic [WARN_N-1:0]    warn_in,
  input  logic [WARN_N-1:0]    warn_mask,
  input  logic                 neg_oc,
  input  logic                 neg_oc_en,
  input  logic                 vout_low,
  input  logic                 ov_ls_latch,
  input  logic                 sync_fault,
  input  logic                 strap_fail,
  input  logic                 clear_faults,
  input  logic [MULT_W-1:0]    restart_mult,
  input  logic [RISE_W-1:0]    rise_cycles,
  output logic                 hs_en,
  output logic                 ls_en,
  output logic                 hs_limit,
  output logic                 pgood,
  output logic                 alert,
  output logic                 share_pull_low,
  output logic                 restart_busy
);
  logic [FAULT_N-1:0] flt_eff, trip_sd, trip_rs;
  logic [WARN_N-1:0]  warn_eff;
  phase_t             phase;
  logic               tmr_load, tmr_done, hs_pend, crow;
  logic               clear_ok, force_off, noc_act, switching;
  logic               alert_q, alert_d, alert_set, alert_clr;

  psfr_qual u_qual (
    .ramp_active (ramp_active),
    .flt_in      (flt_in),
    .flt_resp    (flt_resp),
    .warn_in     (warn_in),
    .flt_eff     (flt_eff),
    .warn_eff    (warn_eff),
    .trip_sd     (trip_sd),
    .trip_rs     (trip_rs)
  );

  assign clear_ok = clear_faults & ~(|flt_in);

  psfr_seq #(.OC_CYC(OC_CYC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .trip_sd     (trip_sd),
    .trip_rs     (trip_rs),
    .pwm_tick    (pwm_tick),
    .clear_ok    (clear_ok),
    .tmr_done    (tmr_done),
    .vout_low    (vout_low),
    .ov_ls_latch (ov_ls_latch),
    .phase       (phase),
    .tmr_load    (tmr_load),
    .hs_pend     (hs_pend),
    .crow        (crow)
  );

  psfr_rtimer #(.MULT_W(MULT_W), .RISE_W(RISE_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .run   (phase == PH_WAIT),
    .mult  (restart_mult),
    .rise  (rise_cycles),
    .done  (tmr_done)
  );

  assign force_off = strap_fail | (sync_fault & is_follower);
  assign noc_act   = neg_oc & neg_oc_en;
  assign switching = ((phase == PH_RUN) | (phase == PH_OCWIN)) & ~force_off;

  assign hs_en          = switching;
  assign ls_en          = crow | (switching & ~noc_act);
  assign hs_limit       = (phase == PH_OCWIN) & hs_pend;
  assign pgood          = (phase == PH_RUN) & ~(|(trip_sd | trip_rs)) & ~warn_eff[W_UV]
                          & ~force_off & ~noc_act;
  assign share_pull_low = force_off;
  assign restart_busy   = (phase == PH_WAIT);

  assign alert_set = (|(flt_eff & ~flt_mask)) | (|(warn_eff & ~warn_mask)) | noc_act;
  assign alert_clr = clear_faults & ~(|flt_in) & ~(|warn_in) & ~neg_oc;

  always_comb begin
    alert_d = alert_q;
    if (alert_set)      alert_d = 1'b1;
    else if (alert_clr) alert_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alert_q <= 1'b0;
    else        alert_q <= alert_d;
  end

  assign alert = alert_q;

  AST_CROW_HS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    crow |-> !hs_en); // R6
  AST_PGOOD_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_RUN) |-> !pgood); // R9
  AST_STRAP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!alert && !alert_set) |=> !alert); // R12
endmodule

// File: tb/psfr_ctrl_test.sv
module psfr_ctrl_test;
  localparam int FN = 9;
  localparam int WN = 4;

  logic clk = 1'b0;
  logic rst_n, pwm_tick, ramp_active, is_follower;
  logic [FN-1:0] flt_in, flt_mask;
  logic [2*FN-1:0] flt_resp;
  logic [WN-1:0] warn_in, warn_mask;
  logic neg_oc, neg_oc_en, vout_low, ov_ls_latch, sync_fault, strap_fail, clear_faults;
  logic [7:0] restart_mult;
  logic [15:0] rise_cycles;
  logic hs_en, ls_en, hs_limit, pgood, alert, share_pull_low, restart_busy;

  always #4 clk = ~clk;

  psfr_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pwm_tick(pwm_tick), .ramp_active(ramp_active),
    .is_follower(is_follower), .flt_in(flt_in), .flt_resp(flt_resp), .flt_mask(flt_mask),
    .warn_in(warn_in), .warn_mask(warn_mask), .neg_oc(neg_oc), .neg_oc_en(neg_oc_en),
    .vout_low(vout_low), .ov_ls_latch(ov_ls_latch), .sync_fault(sync_fault),
    .strap_fail(strap_fail), .clear_faults(clear_faults), .restart_mult(restart_mult),
    .rise_cycles(rise_cycles), .hs_en(hs_en), .ls_en(ls_en), .hs_limit(hs_limit),
    .pgood(pgood), .alert(alert), .share_pull_low(share_pull_low),
    .restart_busy(restart_busy)
  );

  int errors = 0;
  int checks = 0;
  int cyc_no = 0;
  // reference model state: 0 switching, 1 oc window, 2 restart wait, 3 latched off
  int m_ph, m_ticks, m_pend, m_hsl, m_left, m_crow, m_alert;

  function automatic int code_of(int i);
    return int'(flt_resp[2*i +: 2]);
  endfunction

  function automatic bit eff_f(int i);
    return flt_in[i] && !(ramp_active && (i == 4 || i == 5));
  endfunction

  function automatic bit eff_w(int j);
    return warn_in[j] && !(ramp_active && (j == 2 || j == 3));
  endfunction

  task automatic chk(string tag, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b cycle=%0d", tag, nm, act, exp, cyc_no);
    end
  endtask

  task automatic compare(string tag);
    bit fo, run, noc, anytrip;
    fo  = strap_fail || (sync_fault && is_follower);
    run = (m_ph == 0 || m_ph == 1) && !fo;
    noc = neg_oc && neg_oc_en;
    anytrip = 0;
    for (int i = 0; i < FN; i++) if (eff_f(i) && code_of(i) != 0) anytrip = 1;
    chk(tag, "hs_en", hs_en, run);
    chk(tag, "ls_en", ls_en, (m_crow != 0) || (run && !noc));
    chk(tag, "hs_limit", hs_limit, m_ph == 1 && m_hsl != 0);
    chk(tag, "pgood", pgood, m_ph == 0 && !anytrip && !eff_w(3) && !fo && !noc);
    chk(tag, "alert", alert, m_alert != 0);
    chk(tag, "share_pull_low", share_pull_low, fo);
    chk(tag, "restart_busy", restart_busy, m_ph == 2);
  endtask

  task automatic model_step();
    bit sd, rs, ocs, ocr, hst, ovt, aset, aclr, anyf;
    int span;
    sd = 0; rs = 0; ocs = 0; ocr = 0;
    for (int i = 0; i < FN; i++) begin
      if (eff_f(i)) begin
        if (i == 2 || i == 3) begin
          if (code_of(i) >= 2) ocs = 1;
          if (code_of(i) == 1) ocr = 1;
        end else begin
          if (code_of(i) >= 2) sd = 1;
          if (code_of(i) == 1) rs = 1;
        end
      end
    end
    hst = eff_f(3) && code_of(3) != 0;
    ovt = eff_f(4) && code_of(4) != 0;
    span = int'(restart_mult) * int'(rise_cycles);
    if (span < 1) span = 1;
    anyf = (flt_in != 0);
    case (m_ph)
      0: begin
        if (sd) m_ph = 3;
        else if (rs) begin m_ph = 2; m_left = span; end
        else if (ocs || ocr) begin m_ph = 1; m_ticks = 0; m_pend = ocs; m_hsl = hst; end
      end
      1: begin
        if (sd) m_ph = 3;
        else if (rs) begin m_ph = 2; m_left = span; end
        else begin
          m_pend = m_pend | ocs;
          m_hsl = m_hsl | hst;
          if (pwm_tick) begin
            m_ticks++;
            if (m_ticks == 3) begin
              if (m_pend != 0) m_ph = 3;
              else begin m_ph = 2; m_left = span; end
            end
          end
        end
      end
      2: begin
        if (sd || ocs) m_ph = 3;
        else begin
          m_left--;
          if (m_left <= 0) begin
            if (rs || ocr) m_left = span;
            else m_ph = 0;
          end
        end
      end
      default: if (clear_faults && !anyf) m_ph = 0;
    endcase
    if (m_ph != 1) begin m_pend = 0; m_hsl = 0; end
    if (ovt) m_crow = 1;
    else if (m_ph == 0) m_crow = 0;
    else if (vout_low && !ov_ls_latch) m_crow = 0;
    aset = neg_oc && neg_oc_en;
    for (int i = 0; i < FN; i++) if (eff_f(i) && !flt_mask[i]) aset = 1;
    for (int j = 0; j < WN; j++) if (eff_w(j) && !warn_mask[j]) aset = 1;
    aclr = clear_faults && !anyf && (warn_in == 0) && !neg_oc;
    if (aset) m_alert = 1;
    else if (aclr) m_alert = 0;
  endtask

  task automatic cyc(string tag, int n = 1);
    for (int k = 0; k < n; k++) begin
      pwm_tick = (cyc_no % 4 == 3);
      #1;
      compare(tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      cyc_no++;
    end
  endtask

  task automatic set_code(int i, logic [1:0] c);
    flt_resp[2*i +: 2] = c;
  endtask

  task automatic quiet();
    flt_in = '0; warn_in = '0; neg_oc = 0; sync_fault = 0; strap_fail = 0;
    ramp_active = 0; vout_low = 0; clear_faults = 0;
  endtask

  task automatic clear_all(string tag);
    quiet();
    clear_faults = 1;
    cyc(tag);
    clear_faults = 0;
    cyc(tag, 2);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired cycle=%0d", cyc_no);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; quiet(); is_follower = 0; neg_oc_en = 0; ov_ls_latch = 0;
    pwm_tick = 0; flt_mask = '0; warn_mask = '0; restart_mult = 8'd2; rise_cycles = 16'd3;
    flt_resp = '0;
    m_ph = 0; m_ticks = 0; m_pend = 0; m_hsl = 0; m_left = 0; m_crow = 0; m_alert = 0;
    @(negedge clk); @(negedge clk);
    #1 compare("R1");
    rst_n = 1;
    cyc("R1", 3);

    // R8: warnings alert only, UV warning drops pgood
    warn_in = 4'b0001; cyc("R8", 3);
    warn_in = 4'b1000; cyc("R8", 3);
    clear_all("R13");

    // R2: restart and shutdown together latch off
    set_code(0, 2'b01); set_code(1, 2'b10);
    flt_in[0] = 1; flt_in[1] = 1; cyc("R2", 2);
    quiet(); cyc("R2", 8);
    // R13: clear ignored while a fault input is still asserted
    flt_in[1] = 1; clear_faults = 1; cyc("R13", 2);
    clear_all("R13");

    // R3: low-side OC shutdown after three PWM ticks
    set_code(2, 2'b10); flt_in[2] = 1; cyc("R3", 2);
    flt_in[2] = 0; cyc("R3", 14);
    clear_all("R3");

    // R4 + R5: high-side OC restart with limit, then delay 2*3
    set_code(3, 2'b01); flt_in[3] = 1; cyc("R4", 1);
    flt_in[3] = 0; cyc("R4", 14);
    cyc("R5", 10);
    // R5: zero multiplier gives a one-cycle wait
    restart_mult = 8'd0; flt_in[0] = 1; cyc("R5", 1);
    flt_in[0] = 0; cyc("R5", 4);
    restart_mult = 8'd2;
    // R5: shutdown during wait latches off
    flt_in[0] = 1; cyc("R5", 1);
    flt_in[0] = 0; flt_in[1] = 1; cyc("R5", 2);
    clear_all("R5");

    // R6: overvoltage crowbar released by vout_low
    set_code(4, 2'b10); flt_in[4] = 1; cyc("R6", 2);
    flt_in[4] = 0; cyc("R6", 3);
    vout_low = 1; cyc("R6", 2);
    clear_all("R6");
    // R6: latched crowbar stays until switching resumes
    ov_ls_latch = 1; set_code(4, 2'b01); flt_in[4] = 1; cyc("R6", 1);
    flt_in[4] = 0; vout_low = 1; cyc("R6", 10);
    ov_ls_latch = 0; clear_all("R6");

    // R7: negative OC, and crowbar priority
    neg_oc = 1; cyc("R7", 2);
    neg_oc_en = 1; cyc("R7", 3);
    set_code(4, 2'b10); flt_in[4] = 1; cyc("R7", 3);
    clear_all("R7");
    neg_oc_en = 0;

    // R10: ramp gating
    ramp_active = 1; flt_in[4] = 1; flt_in[5] = 1; warn_in = 4'b1100; cyc("R10", 4);
    flt_in[4] = 0; flt_in[5] = 0; warn_in = 0; set_code(6, 2'b10); flt_in[6] = 1; cyc("R10", 2);
    clear_all("R10");

    // R9: ignored fault keeps switching and pgood
    set_code(8, 2'b00); flt_in[8] = 1; cyc("R9", 4);
    clear_all("R9");

    // R11: sync fault on controller, then follower
    sync_fault = 1; cyc("R11", 3);
    is_follower = 1; cyc("R11", 3);
    sync_fault = 0; cyc("R11", 2);
    is_follower = 0;

    // R12: strap failure
    strap_fail = 1; cyc("R12", 3);
    strap_fail = 0; cyc("R12", 2);

    // R14: masked fault still acts without alert
    flt_mask = 9'b010000000; warn_mask = 4'b0010;
    set_code(7, 2'b10); flt_in[7] = 1; warn_in = 4'b0010; cyc("R14", 3);
    clear_all("R14");
    flt_mask = '0; warn_mask = '0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule